// File: doc/BRIEF.md
# Codec Register Command Channel

This block lets software read and write the 16-bit registers of an external audio codec through two 32-bit registers placed in a small register window. Software writes a command word into the command register with a "launch" flag set. The block then presents the command on a parallel request/response port toward the codec side. It drops the launch flag as soon as the codec side has taken the command, so software can poll that flag to know when the command has left.

A read command is followed by a reply that lands in the reply register. The reply carries the index of the register that answered, the 16-bit value and a "fresh reply" flag, so software can tell which request the reply belongs to. If the codec side stays silent, the block creates a reply itself after a fixed number of cycles, with the value 0xFFFF. The same launch flag can start a warm link reset instead of a register access. The command register also holds level controls for codec power-down and link shutdown. The reply register shows the ready state of the two codecs.

Top module: `codec_cmd_chan`

## Requirements
- R1: After reset, the command register (offset 0x0C) reads 0, the reply register (offset 0x08) reads 0 while both ready inputs are low, and `req_valid`, `link_warm_rst`, `pd_prim`, `pd_sec` and `link_off` are low. Reads of any other offset return 0.
- R2: An accepted command-register write with bit 16 set, bit 17 clear and bit 31 clear raises `req_valid` with `req_rd`=0, `req_idx`=bits 30:24 and `req_data`=bits 15:0. These values are held steady until a cycle with `req_ready` high.
- R3: Command-register bit 16 reads 1 from the accepted write until the request handshake, and reads 0 from the cycle after it. No second request is made for that command.
- R4: A command with bit 31 set goes out with `req_rd`=1. The first `resp_valid` that follows it loads reply-register bits 30:24 with `resp_idx` and bits 15:0 with `resp_data`, and sets bit 17.
- R5: A read of the reply register clears bits 17 and 16 from the next cycle; the index and data fields keep their values. A later reply overwrites both fields.
- R6: If no `resp_valid` arrives within TIMEOUT cycles of a read handshake, the reply register gets the requested index in bits 30:24, 0xFFFF in bits 15:0, and bit 17 set.
- R7: A command-register write while bit 16 is still 1 leaves the command register unchanged and sets sticky reply-register bit 16.
- R8: Writing bit 17 together with bit 16 drives `link_warm_rst` high for exactly WARM_CYCLES cycles with no codec request. Bit 16 reads 0 afterwards.
- R9: Reply-register bit 23 follows `prim_rdy` and bit 22 follows `sec_rdy`.
- R10: Command bits 21, 20 and 18 drive `pd_prim`, `pd_sec` and `link_off` from any accepted write, including one with bit 16 clear. A write with bit 16 clear starts no request.
- R11: A `resp_valid` that arrives while no read is awaiting its reply leaves the reply register unchanged.
- R12: A command accepted while a read reply is still outstanding keeps bit 16 at 1 and `req_valid` low until that reply or its timeout. It then goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_rd | input | 1 | Software register read strobe |
| sw_addr | input | ADDR_W | Register offset |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, valid in the same cycle as `sw_rd` |
| req_valid | output | 1 | Codec request pending |
| req_ready | input | 1 | Codec side accepts the request |
| req_rd | output | 1 | 1 = read request, 0 = write request |
| req_idx | output | 7 | Codec register index |
| req_data | output | 16 | Write data toward the codec |
| resp_valid | input | 1 | Read reply present for one cycle |
| resp_idx | input | 7 | Index of the replying register |
| resp_data | input | 16 | Reply value |
| prim_rdy | input | 1 | Primary codec ready |
| sec_rdy | input | 1 | Secondary codec ready |
| link_warm_rst | output | 1 | Warm link reset pulse |
| pd_prim | output | 1 | Primary codec power-down request |
| pd_sec | output | 1 | Secondary codec power-down request |
| link_off | output | 1 | Link shutdown request |

## Verification
The assertions assume that the codec side raises `resp_valid` for single cycles and never changes the request fields on its own. They also assume that software does not read and write in the same cycle. The bench drives every strobe for exactly one cycle, at the falling edge. It raises `req_ready` only while a request is visible. It sends replies either while a read is awaiting them or, on purpose, while the block is idle, to show that such a reply is dropped.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

  localparam int IDX_W = 7;
  localparam int DAT_W = 16;
  localparam int WORD_W = 32;

  // command word fields
  localparam int C_RD    = 31;
  localparam int C_IDX_L = 24;
  localparam int C_PDP   = 21;
  localparam int C_PDS   = 20;
  localparam int C_SHUT  = 18;
  localparam int C_WARM  = 17;
  localparam int C_GO    = 16;

  // reply word fields
  localparam int S_PRDY  = 23;
  localparam int S_SRDY  = 22;
  localparam int S_FRESH = 17;
  localparam int S_OVR   = 16;

  localparam logic [DAT_W-1:0] SILENT_VALUE = 16'hFFFF;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_REQ,
    ENG_WAIT,
    ENG_WARM
  } eng_state_e;

endpackage

// File: rtl/ccc_rst_sync.sv
module ccc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= 1'b1;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ccc_swif.sv
module ccc_swif
  import ccc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] RPL_OFS = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_rd,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] sw_rdata,
  input  logic              prim_rdy,
  input  logic              sec_rdy,
  input  logic              cmd_done,
  input  logic              rep_valid,
  input  logic [IDX_W-1:0]  rep_idx,
  input  logic [DAT_W-1:0]  rep_data,
  output logic              cmd_pend,
  output logic              cmd_warm,
  output logic              cmd_rd,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic [DAT_W-1:0]  cmd_data,
  output logic              pd_prim,
  output logic              pd_sec,
  output logic              link_off
);

  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic              cmd_en;
  logic [IDX_W-1:0]  st_idx_q, st_idx_d;
  logic [DAT_W-1:0]  st_dat_q, st_dat_d;
  logic              st_fresh_q, st_fresh_d;
  logic              st_ovr_q, st_ovr_d;
  logic              st_en;
  logic              wr_cmd, rd_rpl, accept, clash;
  logic [WORD_W-1:0] rpl_word;

  assign wr_cmd = sw_wr && (sw_addr == CMD_OFS);
  assign rd_rpl = sw_rd && (sw_addr == RPL_OFS);
  assign clash  = wr_cmd && cmd_q[C_GO];
  assign accept = wr_cmd && !cmd_q[C_GO];

  // command register next state
  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    if (accept) begin
      cmd_d  = sw_wdata;
      cmd_en = 1'b1;
    end else if (cmd_done) begin
      cmd_d[C_GO] = 1'b0;
      cmd_en      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  // reply register next state
  always_comb begin
    st_idx_d   = st_idx_q;
    st_dat_d   = st_dat_q;
    st_fresh_d = st_fresh_q;
    st_ovr_d   = st_ovr_q;
    if (rep_valid) begin
      st_idx_d   = rep_idx;
      st_dat_d   = rep_data;
      st_fresh_d = 1'b1;
    end else if (rd_rpl) begin
      st_fresh_d = 1'b0;
    end
    if (clash) st_ovr_d = 1'b1;
    else if (rd_rpl) st_ovr_d = 1'b0;
    st_en = rep_valid | rd_rpl | clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_idx_q   <= '0;
      st_dat_q   <= '0;
      st_fresh_q <= 1'b0;
      st_ovr_q   <= 1'b0;
    end else if (st_en) begin
      st_idx_q   <= st_idx_d;
      st_dat_q   <= st_dat_d;
      st_fresh_q <= st_fresh_d;
      st_ovr_q   <= st_ovr_d;
    end
  end

  assign rpl_word = {1'b0, st_idx_q, prim_rdy, sec_rdy, 4'b0000,
                     st_fresh_q, st_ovr_q, st_dat_q};

  always_comb begin
    sw_rdata = '0;
    if (sw_rd) begin
      if (sw_addr == CMD_OFS) sw_rdata = cmd_q;
      else if (sw_addr == RPL_OFS) sw_rdata = rpl_word;
    end
  end

  assign cmd_pend = cmd_q[C_GO];
  assign cmd_warm = cmd_q[C_WARM];
  assign cmd_rd   = cmd_q[C_RD];
  assign cmd_idx  = cmd_q[C_IDX_L +: IDX_W];
  assign cmd_data = cmd_q[DAT_W-1:0];
  assign pd_prim  = cmd_q[C_PDP];
  assign pd_sec   = cmd_q[C_PDS];
  assign link_off = cmd_q[C_SHUT];

  // R3
  go_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_q[C_GO]);

  // R7
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> st_ovr_q && (cmd_q[WORD_W-1:C_WARM] == $past(cmd_q[WORD_W-1:C_WARM])));

  // R5
  fresh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rpl && !rep_valid |=> !st_fresh_q);

endmodule

// File: rtl/ccc_engine.sv
module ccc_engine
  import ccc_pkg::*;
#(
  parameter int TIMEOUT     = 256,
  parameter int WARM_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_pend,
  input  logic             cmd_warm,
  input  logic             cmd_rd,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [DAT_W-1:0] cmd_data,
  output logic             cmd_done,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_rd,
  output logic [IDX_W-1:0] req_idx,
  output logic [DAT_W-1:0] req_data,
  input  logic             resp_valid,
  input  logic [IDX_W-1:0] resp_idx,
  input  logic [DAT_W-1:0] resp_data,
  output logic             rep_valid,
  output logic [IDX_W-1:0] rep_idx,
  output logic [DAT_W-1:0] rep_data,
  output logic             link_warm_rst
);

  localparam int CNT_MAX = (TIMEOUT > WARM_CYCLES) ? TIMEOUT : WARM_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYCLES - 1);

  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] wait_idx_q, wait_idx_d;
  logic             cnt_en, idx_en;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    wait_idx_d = wait_idx_q;
    cnt_en     = 1'b0;
    idx_en     = 1'b0;
    cmd_done   = 1'b0;
    rep_valid  = 1'b0;
    rep_idx    = resp_idx;
    rep_data   = resp_data;
    unique case (state_q)
      ENG_IDLE: begin
        if (cmd_pend) begin
          if (cmd_warm) begin
            state_d = ENG_WARM;
            cnt_d   = WARM_LAST;
            cnt_en  = 1'b1;
          end else begin
            state_d = ENG_REQ;
          end
        end
      end
      ENG_REQ: begin
        if (req_ready) begin
          cmd_done = 1'b1;
          if (cmd_rd) begin
            state_d    = ENG_WAIT;
            cnt_d      = '0;
            cnt_en     = 1'b1;
            wait_idx_d = cmd_idx;
            idx_en     = 1'b1;
          end else begin
            state_d = ENG_IDLE;
          end
        end
      end
      ENG_WAIT: begin
        if (resp_valid) begin
          rep_valid = 1'b1;
          state_d   = ENG_IDLE;
        end else if (cnt_q == TO_LAST) begin
          rep_valid = 1'b1;
          rep_idx   = wait_idx_q;
          rep_data  = SILENT_VALUE;
          state_d   = ENG_IDLE;
        end else begin
          cnt_d  = cnt_q + CNT_W'(1);
          cnt_en = 1'b1;
        end
      end
      ENG_WARM: begin
        if (cnt_q == '0) begin
          cmd_done = 1'b1;
          state_d  = ENG_IDLE;
        end else begin
          cnt_d  = cnt_q - CNT_W'(1);
          cnt_en = 1'b1;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ENG_IDLE;
    else state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_idx_q <= '0;
    else if (idx_en) wait_idx_q <= wait_idx_d;
  end

  assign req_valid     = (state_q == ENG_REQ);
  assign req_rd        = cmd_rd;
  assign req_idx       = cmd_idx;
  assign req_data      = cmd_data;
  assign link_warm_rst = (state_q == ENG_WARM);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_idx) && $stable(req_data) && $stable(req_rd));

  // R12
  req_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cmd_pend);

  // R8
  warm_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_warm_rst |-> cmd_pend && cmd_warm && !req_valid);

  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ENG_WAIT |-> cnt_q <= TO_LAST);

endmodule

// File: rtl/codec_cmd_chan.sv
module codec_cmd_chan
  import ccc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] RPL_OFS = 'h08,
  parameter int TIMEOUT     = 256,
  parameter int WARM_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_rd,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_rd,
  output logic [6:0]        req_idx,
  output logic [15:0]       req_data,
  input  logic              resp_valid,
  input  logic [6:0]        resp_idx,
  input  logic [15:0]       resp_data,
  input  logic              prim_rdy,
  input  logic              sec_rdy,
  output logic              link_warm_rst,
  output logic              pd_prim,
  output logic              pd_sec,
  output logic              link_off
);

  logic             rst_core_n;
  logic             cmd_pend, cmd_warm, cmd_rd, cmd_done;
  logic [IDX_W-1:0] cmd_idx, rep_idx;
  logic [DAT_W-1:0] cmd_data, rep_data;
  logic             rep_valid;

  ccc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_core_n)
  );

  ccc_swif #(
    .ADDR_W  (ADDR_W),
    .CMD_OFS (CMD_OFS),
    .RPL_OFS (RPL_OFS)
  ) u_swif (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sw_wr     (sw_wr),
    .sw_rd     (sw_rd),
    .sw_addr   (sw_addr),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .prim_rdy  (prim_rdy),
    .sec_rdy   (sec_rdy),
    .cmd_done  (cmd_done),
    .rep_valid (rep_valid),
    .rep_idx   (rep_idx),
    .rep_data  (rep_data),
    .cmd_pend  (cmd_pend),
    .cmd_warm  (cmd_warm),
    .cmd_rd    (cmd_rd),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .pd_prim   (pd_prim),
    .pd_sec    (pd_sec),
    .link_off  (link_off)
  );

  ccc_engine #(
    .TIMEOUT     (TIMEOUT),
    .WARM_CYCLES (WARM_CYCLES)
  ) u_engine (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .cmd_pend      (cmd_pend),
    .cmd_warm      (cmd_warm),
    .cmd_rd        (cmd_rd),
    .cmd_idx       (cmd_idx),
    .cmd_data      (cmd_data),
    .cmd_done      (cmd_done),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_rd        (req_rd),
    .req_idx       (req_idx),
    .req_data      (req_data),
    .resp_valid    (resp_valid),
    .resp_idx      (resp_idx),
    .resp_data     (resp_data),
    .rep_valid     (rep_valid),
    .rep_idx       (rep_idx),
    .rep_data      (rep_data),
    .link_warm_rst (link_warm_rst)
  );

endmodule

// File: tb/codec_cmd_chan_bench.sv
module codec_cmd_chan_bench;

  localparam int TO   = 40;
  localparam int WARM = 5;
  localparam logic [7:0] A_CMD = 8'h0C;
  localparam logic [7:0] A_RPL = 8'h08;

  logic        clk, rst_n;
  logic        sw_wr, sw_rd;
  logic [7:0]  sw_addr;
  logic [31:0] sw_wdata, sw_rdata;
  logic        req_valid, req_ready, req_rd;
  logic [6:0]  req_idx, resp_idx;
  logic [15:0] req_data, resp_data;
  logic        resp_valid, prim_rdy, sec_rdy;
  logic        link_warm_rst, pd_prim, pd_sec, link_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  codec_cmd_chan #(.TIMEOUT(TO), .WARM_CYCLES(WARM)) u_codec_cmd_chan (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_rd(req_rd), .req_idx(req_idx), .req_data(req_data),
    .resp_valid(resp_valid), .resp_idx(resp_idx), .resp_data(resp_data),
    .prim_rdy(prim_rdy), .sec_rdy(sec_rdy), .link_warm_rst(link_warm_rst),
    .pd_prim(pd_prim), .pd_sec(pd_sec), .link_off(link_off)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    sw_rd = 1'b1; sw_addr = a;
    #1 d = sw_rdata;
    @(negedge clk);
    sw_rd = 1'b0;
  endtask

  task automatic wait_req(string req);
    int k = 0;
    while (!req_valid && k < 20) begin @(negedge clk); k++; end
    chk(req, {31'd0, req_valid}, 32'd1);
  endtask

  task automatic handshake();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic send_resp(logic [6:0] i, logic [15:0] d);
    resp_valid = 1'b1; resp_idx = i; resp_data = d;
    @(negedge clk);
    resp_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 req_valid", {31'd0, req_valid}, 0);
    chk("R1 warm", {31'd0, link_warm_rst}, 0);
    chk("R1 level outs", {29'd0, pd_prim, pd_sec, link_off}, 0);
    bus_rd(A_CMD, v); chk("R1 cmd reg", v, 0);
    bus_rd(A_RPL, v); chk("R1 reply reg", v, 0);
    bus_rd(8'h04, v); chk("R1 other offset", v, 0);
  endtask

  task automatic t_ready();
    logic [31:0] v;
    prim_rdy = 1'b1; sec_rdy = 1'b0;
    bus_rd(A_RPL, v); chk("R9 prim", {30'd0, v[23:22]}, 32'd2);
    prim_rdy = 1'b0; sec_rdy = 1'b1;
    bus_rd(A_RPL, v); chk("R9 sec", {30'd0, v[23:22]}, 32'd1);
    sec_rdy = 1'b0;
  endtask

  task automatic t_write_cmd();
    logic [31:0] v;
    bus_wr(A_CMD, {1'b0, 7'h26, 8'h01, 16'hBEEF});
    wait_req("R2 request raised");
    chk("R2 rd flag", {31'd0, req_rd}, 0);
    chk("R2 index", {25'd0, req_idx}, 32'h26);
    chk("R2 data", {16'd0, req_data}, 32'hBEEF);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk("R2 held", {31'd0, req_valid}, 1);
    chk("R2 data held", {16'd0, req_data}, 32'hBEEF);
    bus_rd(A_CMD, v); chk("R3 go before", {31'd0, v[16]}, 1);
    handshake();
    chk("R3 single request", {31'd0, req_valid}, 0);
    bus_rd(A_CMD, v); chk("R3 go after", {31'd0, v[16]}, 0);
    chk("R3 no repeat", {31'd0, req_valid}, 0);
  endtask

  task automatic t_read_cmd();
    logic [31:0] v;
    bus_wr(A_CMD, {1'b1, 7'h7C, 8'h01, 16'h0000});
    wait_req("R4 read request");
    chk("R4 rd flag", {31'd0, req_rd}, 1);
    chk("R4 index", {25'd0, req_idx}, 32'h7C);
    handshake();
    @(negedge clk);
    send_resp(7'h7C, 16'h1234);
    bus_rd(A_RPL, v);
    chk("R4 reply", {v[30:24], v[17], v[15:0]}, {7'h7C, 1'b1, 16'h1234});
    bus_rd(A_RPL, v);
    chk("R5 cleared on read", {v[30:24], v[17], v[15:0]}, {7'h7C, 1'b0, 16'h1234});
    bus_wr(A_CMD, {1'b1, 7'h02, 8'h01, 16'h0000});
    wait_req("R5 second read");
    handshake();
    send_resp(7'h02, 16'h5555);
    bus_rd(A_RPL, v);
    chk("R5 overwrite", {v[30:24], v[17], v[15:0]}, {7'h02, 1'b1, 16'h5555});
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    bus_wr(A_CMD, {1'b1, 7'h11, 8'h01, 16'h0000});
    wait_req("R6 request");
    handshake();
    for (int k = 0; k < TO - 3; k++) @(negedge clk);
    bus_rd(A_RPL, v); chk("R6 not yet", {31'd0, v[17]}, 0);
    for (int k = 0; k < 5; k++) @(negedge clk);
    bus_rd(A_RPL, v);
    chk("R6 silent reply", {v[30:24], v[17], v[15:0]}, {7'h11, 1'b1, 16'hFFFF});
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    logic [31:0] first;
    first = {1'b1, 7'h05, 8'h01, 16'h0000};
    bus_wr(A_CMD, first);
    wait_req("R7 request");
    bus_wr(A_CMD, {1'b0, 7'h33, 8'h01, 16'hABCD});
    bus_rd(A_CMD, v); chk("R7 cmd unchanged", v, first);
    bus_rd(A_RPL, v); chk("R7 overrun set", {31'd0, v[16]}, 1);
    bus_rd(A_RPL, v); chk("R5 overrun cleared", {31'd0, v[16]}, 0);
    handshake();
    send_resp(7'h05, 16'h0000);
    bus_rd(A_RPL, v);
  endtask

  task automatic t_idle_resp();
    logic [31:0] v;
    @(negedge clk);
    send_resp(7'h3A, 16'hAAAA);
    bus_rd(A_RPL, v);
    chk("R11 stray reply dropped", {v[30:24], v[17], v[15:0]}, {7'h05, 1'b0, 16'h0000});
  endtask

  task automatic t_queue();
    logic [31:0] v;
    bus_wr(A_CMD, {1'b1, 7'h20, 8'h01, 16'h0000});
    wait_req("R12 read request");
    handshake();
    bus_wr(A_CMD, {1'b0, 7'h21, 8'h01, 16'h0F0F});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R12 held back", {31'd0, req_valid}, 0);
    end
    bus_rd(A_CMD, v); chk("R12 go stays", {31'd0, v[16]}, 1);
    send_resp(7'h20, 16'h4242);
    wait_req("R12 released");
    chk("R12 fields", {req_rd, 8'd0, req_idx, req_data}, {1'b0, 8'd0, 7'h21, 16'h0F0F});
    handshake();
    bus_rd(A_RPL, v);
    chk("R12 reply kept", {v[30:24], v[15:0]}, {7'h20, 16'h4242});
  endtask

  task automatic t_warm();
    logic [31:0] v;
    int hi = 0;
    int reqs = 0;
    bus_wr(A_CMD, 32'h0003_0000);
    for (int k = 0; k < 40; k++) begin
      if (link_warm_rst) hi++;
      if (req_valid) reqs++;
      @(negedge clk);
    end
    chk("R8 pulse width", hi, WARM);
    chk("R8 no request", reqs, 0);
    bus_rd(A_CMD, v); chk("R8 go cleared", {31'd0, v[16]}, 0);
  endtask

  task automatic t_power();
    bus_wr(A_CMD, 32'h0034_0000);
    chk("R10 all set", {29'd0, pd_prim, pd_sec, link_off}, 32'd7);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk("R10 no request", {31'd0, req_valid}, 0);
    bus_wr(A_CMD, 32'h0010_0000);
    chk("R10 sec only", {29'd0, pd_prim, pd_sec, link_off}, 32'd2);
    bus_wr(A_CMD, 32'h0000_0000);
    chk("R10 all clear", {29'd0, pd_prim, pd_sec, link_off}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; sw_wr = 0; sw_rd = 0; sw_addr = '0; sw_wdata = '0;
    req_ready = 0; resp_valid = 0; resp_idx = '0; resp_data = '0;
    prim_rdy = 0; sec_rdy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ready();
    t_write_cmd();
    t_read_cmd();
    t_timeout();
    t_overrun();
    t_idle_resp();
    t_queue();
    t_warm();
    t_power();
    done = 1;
    summary();
    $finish;
  end

endmodule